// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the clock and data lines of a PC keyboard and turns each serial frame into one byte for the host side. Both lines are resynchronised into the system clock domain and filtered. Only a clean high-to-low transition of the keyboard clock counts as a bit strobe. A frame has eleven bits: a 0 start bit, eight data bits least significant first, an odd parity bit and a 1 stop bit.

The finished byte goes to the host together with two flags, one for a parity mismatch and one for a stalled frame. The record stays on the outputs under a valid/ready handshake until the host takes it. While a record waits, or while the host asserts the inhibit input, the block requests that the keyboard clock be pulled low through an open-drain enable. The keyboard is then held off and does not start a new frame.

Top module: `kbd_frame_rx`

## Requirements
- R1: After reset, `rx_valid_o`, `rx_par_err_o`, `rx_tmo_o` and `kbd_clk_oe_o` are 0 (with `inhibit_i` low).
- R2: A well-formed frame (start 0, data bits least significant first, odd parity, stop 1) yields `rx_valid_o`=1 with `rx_byte_o` equal to the sent byte and both error flags 0.
- R3: When the eight data bits plus the parity bit hold an even number of ones, the byte is still delivered, with `rx_par_err_o`=1 and `rx_tmo_o`=0.
- R4: A falling clock edge that finds the data line at 1 while the receiver is idle does not start a frame; a following well-formed frame is received intact.
- R5: A frame whose stop bit is 0 is discarded without a valid record, and the next well-formed frame is received intact.
- R6: If `TIMEOUT_CYC` system cycles pass without a falling clock edge in the middle of a frame, the receiver aborts and presents a record with `rx_tmo_o`=1, `rx_par_err_o`=0 and `rx_byte_o`=0x00. No record appears before that limit.
- R7: While a record is pending and not accepted, `rx_byte_o` and both flags stay unchanged, and `kbd_clk_oe_o` stays 1.
- R8: `inhibit_i`=1 drives `kbd_clk_oe_o` to 1. A frame in progress when inhibit rises is dropped without a record.
- R9: A low pulse on the keyboard clock shorter than `FILTER_LEN` system cycles is not taken as a bit strobe.
- R10: A cycle with `rx_valid_o` and `rx_ready_i` both high consumes the record, and `rx_valid_o` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kbd_clk_i | input | 1 | Keyboard clock line as sensed (asynchronous) |
| kbd_dat_i | input | 1 | Keyboard data line as sensed (asynchronous) |
| inhibit_i | input | 1 | Host request to hold off the keyboard |
| kbd_clk_oe_o | output | 1 | 1 = pull the keyboard clock line low |
| rx_valid_o | output | 1 | Received record pending |
| rx_ready_i | input | 1 | Host accepts the pending record |
| rx_byte_o | output | 8 | Received byte (0x00 after a timeout) |
| rx_par_err_o | output | 1 | Parity mismatch in the pending record |
| rx_tmo_o | output | 1 | Pending record comes from a stalled frame |

## Verification
The assertions assume that the keyboard keeps the data line steady from before each clock fall until the fall has passed the filter. They also assume that, once the open-drain enable is active, the keyboard clock line reads low, as a wired line pulled low by the host would. The keyboard model in the bench changes data only at the start of each high phase, uses half-periods much longer than the filter, and ANDs its clock with the inverted enable. It waits for the enable to drop before it starts any frame. The random frames vary only the byte value and whether the parity is correct. Timeouts, short glitches and framing faults are placed as directed cases.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FULL  = 2'd2
  } rx_state_e;

  localparam int unsigned DATA_BITS = 8;

  // 1 when data plus parity carry an even count of ones (odd parity broken)
  function automatic logic parity_bad(input logic [DATA_BITS-1:0] d, input logic p);
    return ~(^d ^ p);
  endfunction

  // least significant bit arrives first: new bit enters at the top
  function automatic logic [DATA_BITS-1:0] shift_in(input logic [DATA_BITS-1:0] s,
                                                     input logic b);
    return {b, s[DATA_BITS-1:1]};
  endfunction

endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILTER_LEN  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_line_i,
  input  logic dat_line_i,
  output logic fall_o,
  output logic dat_o
);
  localparam int unsigned CW = $clog2(FILTER_LEN + 1);

  logic [SYNC_STAGES-1:0] clk_pipe, dat_pipe;
  logic                   clk_s;
  logic                   lvl_q;
  logic [CW-1:0]          run_q;
  logic                   settle;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clk_pipe[g] <= 1'b1;
          dat_pipe[g] <= 1'b1;
        end else if (g == 0) begin
          clk_pipe[g] <= clk_line_i;
          dat_pipe[g] <= dat_line_i;
        end else begin
          clk_pipe[g] <= clk_pipe[g-1];
          dat_pipe[g] <= dat_pipe[g-1];
        end
      end
    end
  endgenerate

  assign clk_s  = clk_pipe[SYNC_STAGES-1];
  assign dat_o  = dat_pipe[SYNC_STAGES-1];
  assign settle = (clk_s != lvl_q) && (run_q == CW'(FILTER_LEN - 1));
  assign fall_o = settle && lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else if (clk_s == lvl_q) begin
      run_q <= '0;
    end else if (settle) begin
      lvl_q <= clk_s;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  // R9
  fall_sees_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !clk_s);

  // R9
  level_follows_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !lvl_q);

endmodule

// File: rtl/kbd_frame_fsm.sv
module kbd_frame_fsm
  import kbd_rx_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_i,
  input  logic                 dat_i,
  input  logic                 inhibit_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 par_err_o,
  output logic                 tmo_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

  rx_state_e            state_q;
  logic [3:0]           bit_q;
  logic [TW-1:0]        timer_q;
  logic [DATA_BITS-1:0] sh_q;
  logic                 par_q;
  logic                 stall;

  assign stall   = (timer_q == TW'(TIMEOUT_CYC - 1));
  assign valid_o = (state_q == ST_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      timer_q   <= '0;
      sh_q      <= '0;
      par_q     <= 1'b0;
      byte_o    <= '0;
      par_err_o <= 1'b0;
      tmo_o     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (fall_i && !inhibit_i && !dat_i) begin
            state_q <= ST_SHIFT;
            bit_q   <= '0;
            timer_q <= '0;
          end
        end
        ST_SHIFT: begin
          if (inhibit_i) begin
            state_q <= ST_IDLE;
          end else if (fall_i) begin
            timer_q <= '0;
            bit_q   <= bit_q + 1'b1;
            if (bit_q < 4'(DATA_BITS)) begin
              sh_q <= shift_in(sh_q, dat_i);
            end else if (bit_q == 4'(DATA_BITS)) begin
              par_q <= dat_i;
            end else if (dat_i) begin
              state_q   <= ST_FULL;
              byte_o    <= sh_q;
              par_err_o <= parity_bad(sh_q, par_q);
              tmo_o     <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (stall) begin
            state_q   <= ST_FULL;
            byte_o    <= '0;
            par_err_o <= 1'b0;
            tmo_o     <= 1'b1;
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        ST_FULL: begin
          if (ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(byte_o) && $stable(par_err_o) && $stable(tmo_o)));

  // R6
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !(par_err_o && tmo_o));

  // R6
  tmo_from_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_o) && tmo_o) |-> ($past(state_q) == ST_SHIFT && byte_o == '0));

  // R8
  inhibit_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && inhibit_i) |=> !valid_o);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i) |=> !valid_o);

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILTER_LEN  = 4,
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_clk_i,
  input  logic       kbd_dat_i,
  input  logic       inhibit_i,
  output logic       kbd_clk_oe_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i,
  output logic [7:0] rx_byte_o,
  output logic       rx_par_err_o,
  output logic       rx_tmo_o
);
  logic bit_fall;
  logic bit_dat;

  kbd_line_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILTER_LEN  (FILTER_LEN)
  ) sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_line_i (kbd_clk_i),
    .dat_line_i (kbd_dat_i),
    .fall_o     (bit_fall),
    .dat_o      (bit_dat)
  );

  kbd_frame_fsm #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_i    (bit_fall),
    .dat_i     (bit_dat),
    .inhibit_i (inhibit_i),
    .ready_i   (rx_ready_i),
    .valid_o   (rx_valid_o),
    .byte_o    (rx_byte_o),
    .par_err_o (rx_par_err_o),
    .tmo_o     (rx_tmo_o)
  );

  assign kbd_clk_oe_o = inhibit_i | rx_valid_o;

  // R7
  pending_holds_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> kbd_clk_oe_o);

  // R8
  inhibit_drives_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |-> kbd_clk_oe_o);

endmodule

// File: tb/kbd_frame_rx_tb_top.sv
`timescale 1ns/1ps
module kbd_frame_rx_tb_top;
  localparam int FILTER  = 4;
  localparam int TIMEOUT = 1500;
  localparam int HALF    = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kb_clk_drv = 1'b1;
  logic       kb_dat = 1'b1;
  logic       inhibit = 1'b0;
  logic       rx_ready = 1'b0;
  logic       oe, valid, perr, tmo;
  logic [7:0] rbyte;
  logic       line_clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign line_clk = kb_clk_drv & ~oe;

  kbd_frame_rx #(
    .SYNC_STAGES (2),
    .FILTER_LEN  (FILTER),
    .TIMEOUT_CYC (TIMEOUT)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .kbd_clk_i    (line_clk),
    .kbd_dat_i    (kb_dat),
    .inhibit_i    (inhibit),
    .kbd_clk_oe_o (oe),
    .rx_valid_o   (valid),
    .rx_ready_i   (rx_ready),
    .rx_byte_o    (rbyte),
    .rx_par_err_o (perr),
    .rx_tmo_o     (tmo)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit odd_par(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return (ones % 2 == 0);
  endfunction

  function automatic logic [10:0] frame(input logic [7:0] d, input bit bad_par,
                                        input bit start_b, input bit stop_b);
    logic p = odd_par(d) ^ bad_par;
    return {stop_b, p, d, start_b};
  endfunction

  task automatic send_bits(input logic [10:0] bits, input int nbits, input bit glitch);
    while (oe) tick(1);
    tick(20);
    for (int i = 0; i < nbits; i++) begin
      kb_dat = bits[i];
      if (glitch && i == 3) begin
        tick(10);
        kb_clk_drv = 1'b0;
        tick(2);
        kb_clk_drv = 1'b1;
        tick(HALF - 12);
      end else begin
        tick(HALF);
      end
      kb_clk_drv = 1'b0;
      tick(HALF);
      kb_clk_drv = 1'b1;
    end
    tick(10);
    kb_dat = 1'b1;
  endtask

  task automatic expect_rec(input string req, input logic [7:0] b, input bit pe, input bit te);
    check(valid == 1'b1, req, "valid", valid, 1);
    check(rbyte == b, req, "byte", rbyte, b);
    check(perr == pe, req, "parity flag", perr, pe);
    check(tmo == te, req, "timeout flag", tmo, te);
  endtask

  task automatic take();
    rx_ready = 1'b1;
    tick(1);
    rx_ready = 1'b0;
    check(valid == 1'b0, "R10", "valid after accept", valid, 0);
  endtask

  initial begin : watchdog
    tick(150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] b;
    bit bp;
    int unsigned seed;
    seed = $urandom(32'h5eed);
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1
    check(valid == 0, "R1", "valid", valid, 0);
    check(oe == 0, "R1", "clock oe", oe, 0);
    check(perr == 0 && tmo == 0, "R1", "flags", {perr, tmo}, 0);

    // R2 basic frame
    send_bits(frame(8'hA5, 0, 0, 1), 11, 0);
    expect_rec("R2", 8'hA5, 0, 0);
    check(oe == 1, "R7", "clock held while pending", oe, 1);

    // R7 hold for a long time
    tick(300);
    expect_rec("R7", 8'hA5, 0, 0);
    check(oe == 1, "R7", "clock still held", oe, 1);
    take();

    // R3 parity error
    send_bits(frame(8'h3C, 1, 0, 1), 11, 0);
    expect_rec("R3", 8'h3C, 1, 0);
    take();

    // R5 stop bit 0 discards
    send_bits(frame(8'h55, 0, 0, 0), 11, 0);
    tick(50);
    check(valid == 0, "R5", "no record after bad stop", valid, 0);
    send_bits(frame(8'h12, 0, 0, 1), 11, 0);
    expect_rec("R5", 8'h12, 0, 0);
    take();

    // R4 lone fall with data high
    send_bits(11'h001, 1, 0);
    tick(50);
    check(valid == 0, "R4", "no record after high start", valid, 0);
    send_bits(frame(8'h81, 0, 0, 1), 11, 0);
    expect_rec("R4", 8'h81, 0, 0);
    take();

    // R9 short glitch
    send_bits(frame(8'h6E, 0, 0, 1), 11, 1);
    expect_rec("R9", 8'h6E, 0, 0);
    take();

    // R6 stalled frame
    send_bits(frame(8'hF0, 0, 0, 1), 5, 0);
    tick(TIMEOUT - 300);
    check(valid == 0, "R6", "no record before limit", valid, 0);
    tick(400);
    expect_rec("R6", 8'h00, 0, 1);
    take();

    // R8 inhibit
    inhibit = 1'b1;
    tick(3);
    check(oe == 1, "R8", "inhibit drives oe", oe, 1);
    inhibit = 1'b0;
    tick(3);
    send_bits(frame(8'h99, 0, 0, 1), 4, 0);
    inhibit = 1'b1;
    tick(100);
    check(valid == 0, "R8", "aborted frame silent", valid, 0);
    inhibit = 1'b0;
    tick(TIMEOUT + 100);
    check(valid == 0, "R8", "still no record", valid, 0);
    check(oe == 0, "R8", "oe released", oe, 0);
    send_bits(frame(8'hC3, 0, 0, 1), 11, 0);
    expect_rec("R8", 8'hC3, 0, 0);
    take();

    // random frames (R2, R3)
    for (int k = 0; k < 24; k++) begin
      b  = 8'($urandom);
      bp = ($urandom % 4) == 0;
      send_bits(frame(b, bp, 0, 1), 11, 0);
      expect_rec(bp ? "R3" : "R2", b, bp, 0);
      tick($urandom % 20);
      take();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule